// File: doc/BRIEF.md
# Half to single precision widening converter

This block turns a 16-bit binary floating-point value into a 32-bit IEEE single-precision value. The widening never rounds: every half-width value has an exact single-precision image. So the datapath is purely combinational up to one output register. Each clock can accept a new operand, and its result appears one cycle later.

A mode input picks how the top exponent code of the half value is read. In standard mode the top code marks infinity or NaN. In extended mode that code is an ordinary binade, which gives one more octave of finite range and no special values. Subnormal inputs are normalized by a leading-one search over the fraction. In standard mode a signalling NaN is made quiet, and a flag reports the invalid operation.

Top module: `hcvt_widen`

## Requirements
- R1: A half input with sign in bit 15, exponent code E in bits 14:10 (0 < E < 31) and fraction F in bits 9:0 produces sign bit 31 equal to bit 15, exponent field (bits 30:23) E+112, and fraction field (bits 22:0) F followed by 13 zero bits.
- R2: An input with E=0 and F=0 produces an all-zero result except bit 31, which copies the input sign.
- R3: An input with E=0 and F≠0 is normalized. With the leading one of F at bit p, the shift is s=10-p. The exponent field becomes 113-s, and the fraction field becomes the low 10 bits of F<<s followed by 13 zeros.
- R4: In standard mode (`in_ext`=0), E=31 with F=0 produces exponent field 255 and a zero fraction field, with the sign kept.
- R5: In standard mode, E=31 with F≠0 produces exponent field 255 and fraction field (F with bit 9 forced to 1) followed by 13 zeros, with the sign kept.
- R6: `out_invalid` is 1 only for a standard-mode input with E=31, F≠0 and F bit 9 clear. It is 0 for every other input.
- R7: In extended mode (`in_ext`=1), E=31 is converted like any normal exponent: exponent field 143, and the fraction copied as in R1. The inputs that R1, R2 and R3 cover give the same results in both modes.
- R8: A result and its flag appear on the outputs one clock after the input is accepted, and `out_valid` equals `in_valid` delayed by one clock. Synchronous active-low reset clears `out_valid`, `out_single` and `out_invalid`.
- R9: In a cycle where `in_valid` is 0, the outputs `out_single` and `out_invalid` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operand on `in_half` is to be converted |
| in_half | input | 16 | Half-width floating-point operand |
| in_ext | input | 1 | 1 selects the extended half format with no special values |
| out_valid | output | 1 | Result registers hold a fresh result |
| out_single | output | 32 | Single-precision result |
| out_invalid | output | 1 | Signalling NaN was quieted |

## Verification
Every result, together with its flag and `out_valid`, is due exactly one rising edge after the operand is presented. The bench drives each operand at a falling edge and compares the outputs at the following falling edge, half a period after the capturing edge. Operands from the vector table are presented back to back, so each comparison also proves that the previous operand does not leak into the next result. After `in_valid` drops, the bench checks at the next falling edge that `out_valid` has cleared and that the data outputs still hold the last result.

// File: rtl/hcvt_pkg.sv
// Shared widths, field layouts and class codes for the half-to-single converter.
// Assumes binary16-style input layout and IEEE single-precision output layout.
package hcvt_pkg;
    localparam int H_EXP_W   = 5;
    localparam int H_FRAC_W  = 10;
    localparam int H_W       = 1 + H_EXP_W + H_FRAC_W;
    localparam int S_EXP_W   = 8;
    localparam int S_FRAC_W  = 23;
    localparam int S_W       = 1 + S_EXP_W + S_FRAC_W;
    localparam int H_BIAS    = (1 << (H_EXP_W - 1)) - 1;
    localparam int S_BIAS    = (1 << (S_EXP_W - 1)) - 1;
    localparam int BIAS_DIFF = S_BIAS - H_BIAS;
    localparam int FRAC_PAD  = S_FRAC_W - H_FRAC_W;
    localparam int SHIFT_W   = $clog2(H_FRAC_W + 1);

    typedef struct packed {
        logic                sign;
        logic [H_EXP_W-1:0]  exp;
        logic [H_FRAC_W-1:0] frac;
    } half_t;

    typedef struct packed {
        logic                sign;
        logic [S_EXP_W-1:0]  exp;
        logic [S_FRAC_W-1:0] frac;
    } single_t;

    typedef enum logic [2:0] {
        CL_ZERO,
        CL_SUBN,
        CL_NORM,
        CL_INF,
        CL_NAN
    } hclass_e;
endpackage

// File: rtl/hcvt_lead_one.sv
// Priority encoder: reports how far the leading one of VEC must move left
// to land at bit position W (the hidden-bit slot). Assumes the caller
// ignores SHIFT when FOUND is 0.
module hcvt_lead_one #(
    parameter int W     = 10,
    parameter int SH_W  = $clog2(W + 1)
) (
    input  logic [W-1:0]    vec,
    output logic [SH_W-1:0] shift,
    output logic            found
);
    // Scan upward so the highest set bit is the last to win.
    always_comb begin
        shift = '0;
        found = 1'b0;
        for (int i = 0; i < W; i++) begin
            if (vec[i]) begin
                shift = SH_W'(W - i);
                found = 1'b1;
            end
        end
    end
endmodule

// File: rtl/hcvt_core.sv
// Combinational widening of one half-width value to single precision.
// Classifies the operand, normalizes subnormals, rebiases the exponent and
// quiets NaNs. Assumes EXT_MODE=1 means the top exponent code is finite.
module hcvt_core
    import hcvt_pkg::*;
(
    input  half_t   op,
    input  logic    ext_mode,
    output single_t res,
    output logic    invalid
);
    localparam logic [S_EXP_W-1:0] EXP_OFS  = S_EXP_W'(BIAS_DIFF);
    localparam logic [S_EXP_W-1:0] SUBN_OFS = S_EXP_W'(BIAS_DIFF + 1);
    localparam int                 QBIT     = H_FRAC_W - 1;

    hclass_e             cls;
    logic [SHIFT_W-1:0]  lz_shift;
    logic                lz_found;
    logic [H_FRAC_W:0]   norm_wide;
    logic [H_FRAC_W-1:0] nan_frac;

    hcvt_lead_one #(.W(H_FRAC_W), .SH_W(SHIFT_W)) lead_i (
        .vec   (op.frac),
        .shift (lz_shift),
        .found (lz_found)
    );

    // Sort the operand into one of the five classes under the selected mode.
    always_comb begin
        if (op.exp == '0)
            cls = lz_found ? CL_SUBN : CL_ZERO;
        else if (op.exp == '1 && !ext_mode)
            cls = (op.frac == '0) ? CL_INF : CL_NAN;
        else
            cls = CL_NORM;
    end

    // Move the subnormal leading one into the hidden-bit slot.
    always_comb norm_wide = {1'b0, op.frac} << lz_shift;

    // Quiet a NaN payload by setting its top fraction bit.
    always_comb begin
        nan_frac        = op.frac;
        nan_frac[QBIT]  = 1'b1;
    end

    // Assemble the single-precision fields and the invalid flag per class.
    always_comb begin
        res.sign = op.sign;
        invalid  = 1'b0;
        unique case (cls)
            CL_ZERO: begin
                res.exp  = '0;
                res.frac = '0;
            end
            CL_SUBN: begin
                res.exp  = SUBN_OFS - S_EXP_W'(lz_shift);
                res.frac = {norm_wide[H_FRAC_W-1:0], {FRAC_PAD{1'b0}}};
            end
            CL_INF: begin
                res.exp  = '1;
                res.frac = '0;
            end
            CL_NAN: begin
                res.exp  = '1;
                res.frac = {nan_frac, {FRAC_PAD{1'b0}}};
                invalid  = ~op.frac[QBIT];
            end
            default: begin
                res.exp  = S_EXP_W'(op.exp) + EXP_OFS;
                res.frac = {op.frac, {FRAC_PAD{1'b0}}};
            end
        endcase
    end
endmodule

// File: rtl/hcvt_widen.sv
// Top of the half-to-single converter: combinational core followed by one
// output register stage. Accepts one operand per clock; result one clock
// later. Synchronous active-low reset clears all outputs.
module hcvt_widen
    import hcvt_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           in_valid,
    input  logic [H_W-1:0] in_half,
    input  logic           in_ext,
    output logic           out_valid,
    output logic [S_W-1:0] out_single,
    output logic           out_invalid
);
    single_t core_res;
    logic    core_inv;

    hcvt_core core_i (
        .op       (half_t'(in_half)),
        .ext_mode (in_ext),
        .res      (core_res),
        .invalid  (core_inv)
    );

    // Valid pipeline bit: follows the input by one clock.
    always_ff @(posedge clk) begin
        if (!rst_n) out_valid <= 1'b0;
        else        out_valid <= in_valid;
    end

    // Result registers: load only on an accepted operand, else hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_single  <= '0;
            out_invalid <= 1'b0;
        end else if (in_valid) begin
            out_single  <= core_res;
            out_invalid <= core_inv;
        end
    end

    AST_VALID_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R8
    AST_VALID_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid); // R8
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_single) && $stable(out_invalid))); // R9
    AST_INV_IS_QNAN: assert property (@(posedge clk) disable iff (!rst_n)
        out_invalid |-> (out_single[30:23] == 8'hFF && out_single[22])); // R6
    AST_EXT_FINITE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ext) |=> (out_single[30:23] != 8'hFF && !out_invalid)); // R7
    AST_ZERO_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_half[14:0] == '0) |=>
        (out_single == {$past(in_half[15]), 31'd0})); // R2
endmodule

// File: tb/hcvt_widen_tb.sv
// Self-checking bench: vector table walked back to back, then directed
// tests for reset, idle hold and valid timing.
module hcvt_widen_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC       = 24;

    typedef struct packed {
        logic        ext;
        logic [15:0] half;
        logic [31:0] single;
        logic        inv;
    } vec_t;

    localparam vec_t VECS [NVEC] = '{
        {1'b0, 16'h3C00, 32'h3F800000, 1'b0},
        {1'b0, 16'hC000, 32'hC0000000, 1'b0},
        {1'b0, 16'h7BFF, 32'h477FE000, 1'b0},
        {1'b0, 16'h0400, 32'h38800000, 1'b0},
        {1'b0, 16'h0000, 32'h00000000, 1'b0},
        {1'b0, 16'h8000, 32'h80000000, 1'b0},
        {1'b0, 16'h0001, 32'h33800000, 1'b0},
        {1'b0, 16'h0200, 32'h38000000, 1'b0},
        {1'b0, 16'h03FF, 32'h387FC000, 1'b0},
        {1'b0, 16'h8155, 32'hB7AA8000, 1'b0},
        {1'b0, 16'h7C00, 32'h7F800000, 1'b0},
        {1'b0, 16'hFC00, 32'hFF800000, 1'b0},
        {1'b0, 16'h7E00, 32'h7FC00000, 1'b0},
        {1'b0, 16'h7C01, 32'h7FC02000, 1'b1},
        {1'b0, 16'hFD55, 32'hFFEAA000, 1'b1},
        {1'b0, 16'h3C00, 32'h3F800000, 1'b0},
        {1'b1, 16'h7C00, 32'h47800000, 1'b0},
        {1'b1, 16'h7FFF, 32'h47FFE000, 1'b0},
        {1'b1, 16'h7C01, 32'h47802000, 1'b0},
        {1'b1, 16'hFE00, 32'hC7C00000, 1'b0},
        {1'b1, 16'h3C00, 32'h3F800000, 1'b0},
        {1'b1, 16'h0001, 32'h33800000, 1'b0},
        {1'b1, 16'h8000, 32'h80000000, 1'b0},
        {1'b1, 16'h8155, 32'hB7AA8000, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [15:0] in_half = '0;
    logic        in_ext = 1'b0;
    logic        out_valid;
    logic [31:0] out_single;
    logic        out_invalid;

    int checks = 0;
    int errors = 0;

    hcvt_widen dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .in_half     (in_half),
        .in_ext      (in_ext),
        .out_valid   (out_valid),
        .out_single  (out_single),
        .out_invalid (out_invalid)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Requirement tag for a table entry, derived from its input fields.
    function automatic string req_of(input vec_t v);
        if (v.half[14:10] == 5'd0) return (v.half[9:0] == '0) ? "R2" : "R3";
        if (v.half[14:10] == 5'd31 && !v.ext) return (v.half[9:0] == '0) ? "R4" : "R5";
        if (v.half[14:10] == 5'd31) return "R7";
        return "R1";
    endfunction

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        // Reset state (R8).
        repeat (3) @(negedge clk);
        check("R8", "reset out_valid", 32'(out_valid), 32'd0);
        check("R8", "reset out_single", out_single, 32'd0);
        check("R8", "reset out_invalid", 32'(out_invalid), 32'd0);
        rst_n = 1'b1;

        // Table walked back to back; each result sampled one clock later.
        in_valid = 1'b1;
        in_ext   = VECS[0].ext;
        in_half  = VECS[0].half;
        for (int i = 0; i < NVEC; i++) begin
            @(negedge clk);
            check("R8", "out_valid", 32'(out_valid), 32'd1);
            check(req_of(VECS[i]), "out_single", out_single, VECS[i].single);
            check("R6", "out_invalid", 32'(out_invalid), 32'(VECS[i].inv));
            if (i + 1 < NVEC) begin
                in_ext  = VECS[i+1].ext;
                in_half = VECS[i+1].half;
            end
        end

        // Idle cycle with a different operand: outputs hold (R9, R8).
        in_valid = 1'b0;
        in_ext   = 1'b0;
        in_half  = 16'h7C01;
        @(negedge clk);
        check("R8", "out_valid after idle", 32'(out_valid), 32'd0);
        check("R9", "held out_single", out_single, 32'hB7AA8000);
        check("R9", "held out_invalid", 32'(out_invalid), 32'd0);
        @(negedge clk);
        check("R9", "still held", out_single, 32'hB7AA8000);

        // Single operand after a gap: sNaN sets flag, valid pulses one cycle.
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        in_half  = 16'h3C00;
        check("R8", "pulse valid", 32'(out_valid), 32'd1);
        check("R6", "gap sNaN flag", 32'(out_invalid), 32'd1);
        check("R5", "gap sNaN value", out_single, 32'h7FC02000);
        @(negedge clk);
        check("R8", "pulse ends", 32'(out_valid), 32'd0);
        check("R9", "flag held", 32'(out_invalid), 32'd1);

        // Mid-run reset clears everything (R8).
        rst_n = 1'b0;
        @(negedge clk);
        check("R8", "reset clears data", out_single, 32'd0);
        check("R8", "reset clears flag", 32'(out_invalid), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        finish_run();
    end
endmodule